// File: doc/BRIEF.md
# Burst Read Compare Failure Logger

This block sits on the read-return side of a memory test path. During a test mode, each valid beat pair returned from a nine-lane data bus is compared against expected data, lane by lane. The block keeps nine sticky 16-bit log registers, one per byte lane. It also drives an 8-bit observation port, which shows either a byte of live read data or a two-bit pass/fail status.

A configuration word chooses several things. It picks which lane or lanes are compared. It picks the burst position to log, or asks for the first failing position in any burst. It chooses whether the logs hold the failing bits or the raw read data. It also sets the default expected data for lanes that are outside the compare and what the observation port shows.

A burst is either four or eight beats long. Each position is one early/late beat pair, so a burst has two or four positions. Logs and flags stay frozen after a capture until a clear pulse is given.

Top module: `burst_fail_logger`

## Requirements
- R1: After a synchronous active-low reset, all nine logs read zero, both status flags are low, the observation port is zero and the configuration word is zero.
- R2: The configuration word (29 bits) is loaded on `cfg_wr` at a rising edge. Its fields are:
  - compare lane: bits 3:0
  - observed lane: bits 7:4
  - position select: bits 9:8
  - first-failure enable: bit 10
  - failing-bits log mode: bit 11
  - observe-data mode: bit 12
  - default data: bits 28:13, with the default early byte in bits 28:21 and the default late byte in bits 20:13.
- R3: Lane n is `rd_early`/`rd_late` bits [8n+7:8n]. A compared lane fails when its early byte differs from `exp_early` or its late byte differs from `exp_late`. A late-only difference counts as a failure. Compare-lane value 15 compares all nine lanes.
- R4: A lane outside the compare never reports a failure. Compare-lane values 9 to 14 compare no lane.
- R5: A valid beat with `beat_first` high is position 0. Each further valid beat advances the position by one. Positions at or past the burst end (2 for four-beat mode, 4 for eight-beat mode) are never captured.
- R6: With first-failure disabled, a capture happens only at the position equal to the position select, and only if that position has a failure.
- R7: In four-beat mode, a position select of 2 or 3 never captures.
- R8: With first-failure enabled, the first failing position of any burst is captured.
- R9: In failing-bits mode, lane n's log at `log_flat[16n+15:16n]` holds {late XOR expected late, early XOR expected early}. The expected bytes come from `exp_*` for compared lanes and from the default data for the other lanes.
- R10: In raw mode, each lane's log holds {late byte, early byte} of the captured beat pair.
- R11: A capture sets `log_done`. After that, no log changes until a clear. `fail_seen` rises on any compared-lane failure at any position, whether or not it is logged.
- R12: A `log_clr` pulse zeroes all logs and both flags. It takes priority over a capture in the same cycle.
- R13: In observe-data mode, `obs_port` shows the early byte of the observed lane from the most recent valid beat. It shows zero if that lane number is 9 or above. Otherwise `obs_port` is {000000, log_done, fail_seen}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 29 | Configuration word |
| log_clr | input | 1 | Clears logs and flags |
| beat_vld | input | 1 | A beat pair is present this cycle |
| beat_first | input | 1 | This beat pair opens a burst |
| bl8 | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| rd_early | input | 72 | Early read bytes, nine lanes |
| rd_late | input | 72 | Late read bytes, nine lanes |
| exp_early | input | 8 | Expected early byte for compared lanes |
| exp_late | input | 8 | Expected late byte for compared lanes |
| obs_port | output | 8 | Observed data byte or status |
| log_flat | output | 144 | Nine 16-bit logs, lane 0 in the low bits |
| log_done | output | 1 | A log has been captured |
| fail_seen | output | 1 | A compared-lane failure was seen |

## Verification
The bench sends failures at chosen positions in both burst lengths and checks where the capture lands. A design that mapped the position select wrongly would log the wrong beat. A design that let a four-beat burst match select 2 or 3 would capture when it must not. The bench also injects failures into lanes outside the compare, including through compare values 9 to 14, and it sends late-only differences; a decoder that ignored either would raise or miss flags. Further checks cover:
- second failures after a capture, where a design that lost stickiness would overwrite the logs;
- a clear in the same cycle as a failing beat, where a design with the priority reversed would keep the capture;
- out-of-range observed lanes, where a design without the guard would show stale data.

// File: rtl/blog_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the configuration word layout for the
// burst compare failure logger. Assumes 8-bit lanes, so the default
// data field is two lane bytes wide.
package blog_pkg;
    localparam int NLANE     = 9;
    localparam int BW        = 8;
    localparam int SELW      = 4;
    localparam int MAX_POS   = 4;
    localparam logic [SELW-1:0] ALL_LANES = 4'hF;

    // Configuration word, MSB first: default data, modes, lane selects
    typedef struct packed {
        logic [BW-1:0]   dflt_early;
        logic [BW-1:0]   dflt_late;
        logic            obs_data;
        logic            log_xor;
        logic            first_fail;
        logic [1:0]      pos_sel;
        logic [SELW-1:0] obs_lane;
        logic [SELW-1:0] cmp_lane;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/bl_pos_track.sv
`timescale 1ns/1ps
// Module: bl_pos_track
// Tracks the burst position of each valid beat pair. A beat flagged as
// first is position 0; later beats count up, saturating one past the
// largest position. Assumes beat_first marks every burst start.
module bl_pos_track #(
    parameter int MAXPOS = 4,
    localparam int CW = $clog2(MAXPOS + 1),
    localparam int PW = $clog2(MAXPOS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_vld,
    input  logic          beat_first,
    input  logic          bl8,
    output logic [PW-1:0] pos,
    output logic          pos_ok
);
    logic [CW-1:0] nxt_idx;
    logic [CW-1:0] pos_full;
    logic [CW-1:0] pos_lim;

    // Holds the position index the next valid beat will take
    always_ff @(posedge clk) begin
        if (!rst_n)
            nxt_idx <= '0;
        else if (beat_vld) begin
            if (beat_first)
                nxt_idx <= CW'(1);
            else if (nxt_idx != CW'(MAXPOS))
                nxt_idx <= nxt_idx + CW'(1);
        end
    end

    // Current position and whether it lies inside the burst
    always_comb begin
        pos_full = beat_first ? '0 : nxt_idx;
        pos_lim  = bl8 ? CW'(MAXPOS) : CW'(MAXPOS / 2);
        pos_ok   = pos_full < pos_lim;
        pos      = pos_full[PW-1:0];
    end

    // R5
    second_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !beat_first && $past(beat_vld && beat_first)) |-> (pos_full == CW'(1)));
endmodule

// File: rtl/bl_lane_cmp.sv
`timescale 1ns/1ps
// Module: bl_lane_cmp
// Compares one lane's early/late bytes against a reference. The
// reference is the expected data when the lane is selected, else the
// default data. Only a selected lane can flag a mismatch.
module bl_lane_cmp #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]   rd_e,
    input  logic [BW-1:0]   rd_l,
    input  logic [BW-1:0]   exp_e,
    input  logic [BW-1:0]   exp_l,
    input  logic [BW-1:0]   dflt_e,
    input  logic [BW-1:0]   dflt_l,
    input  logic            sel,
    output logic [2*BW-1:0] diff,
    output logic            mism
);
    logic [BW-1:0] ref_e;
    logic [BW-1:0] ref_l;

    // Pick reference bytes and form the failing-bit word
    always_comb begin
        ref_e = sel ? exp_e : dflt_e;
        ref_l = sel ? exp_l : dflt_l;
        diff  = {rd_l ^ ref_l, rd_e ^ ref_e};
        mism  = sel && (diff != '0);
    end
endmodule

// File: rtl/bl_log_bank.sv
`timescale 1ns/1ps
// Module: bl_log_bank
// Nine (NLANE) sticky log registers plus capture-done and
// failure-seen flags. The first capture freezes the logs; clear wins
// over a capture in the same cycle.
module bl_log_bank #(
    parameter int NLANE = 9,
    parameter int LOGW  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  cap,
    input  logic                  seen,
    input  logic [NLANE*LOGW-1:0] cap_data,
    output logic [NLANE*LOGW-1:0] log_flat,
    output logic                  done,
    output logic                  any_fail
);
    // Sticky status flags
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done     <= 1'b0;
            any_fail <= 1'b0;
        end else begin
            if (cap)
                done <= 1'b1;
            if (seen)
                any_fail <= 1'b1;
        end
    end

    for (genvar n = 0; n < NLANE; n++) begin : g_log
        // One lane log, written only by the first capture
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                log_flat[n*LOGW +: LOGW] <= '0;
            else if (cap && !done)
                log_flat[n*LOGW +: LOGW] <= cap_data[n*LOGW +: LOGW];
        end
    end

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);
    // R11
    log_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> $stable(log_flat));
    // R12
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && !any_fail && log_flat == '0));
endmodule

// File: rtl/burst_fail_logger.sv
`timescale 1ns/1ps
// Module: burst_fail_logger
// Compares returned read beat pairs with expected data on nine byte
// lanes and logs them at a chosen or first failing burst position.
// Drives an observation byte with live data or status. Assumes one
// beat pair per valid cycle and 8-bit lanes.
module burst_fail_logger
    import blog_pkg::*;
#(
    parameter int LANES = NLANE,
    parameter int LW    = BW,
    localparam int LOGW = 2 * LW,
    localparam int PW   = $clog2(MAX_POS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  log_clr,
    input  logic                  beat_vld,
    input  logic                  beat_first,
    input  logic                  bl8,
    input  logic [LANES*LW-1:0]   rd_early,
    input  logic [LANES*LW-1:0]   rd_late,
    input  logic [LW-1:0]         exp_early,
    input  logic [LW-1:0]         exp_late,
    output logic [LW-1:0]         obs_port,
    output logic [LANES*LOGW-1:0] log_flat,
    output logic                  log_done,
    output logic                  fail_seen
);
    cfg_t                  cfg_q;
    logic [PW-1:0]         pos;
    logic                  pos_ok;
    logic [LANES-1:0]      mism_vec;
    logic [LANES*LOGW-1:0] diff_flat;
    logic [LANES*LOGW-1:0] cap_data;
    logic                  any_mism;
    logic                  pos_hit;
    logic                  cap;
    logic                  seen;
    logic [LW-1:0]         obs_pick;
    logic [LW-1:0]         last_byte;

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_t'(cfg_wdata);
    end

    bl_pos_track #(.MAXPOS(MAX_POS)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_vld   (beat_vld),
        .beat_first (beat_first),
        .bl8        (bl8),
        .pos        (pos),
        .pos_ok     (pos_ok)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic lane_sel;
        // Lane is compared when named or when all lanes are chosen
        assign lane_sel = (cfg_q.cmp_lane == ALL_LANES) || (cfg_q.cmp_lane == SELW'(n));

        bl_lane_cmp #(.BW(LW)) u_cmp (
            .rd_e   (rd_early[n*LW +: LW]),
            .rd_l   (rd_late[n*LW +: LW]),
            .exp_e  (exp_early),
            .exp_l  (exp_late),
            .dflt_e (cfg_q.dflt_early),
            .dflt_l (cfg_q.dflt_late),
            .sel    (lane_sel),
            .diff   (diff_flat[n*LOGW +: LOGW]),
            .mism   (mism_vec[n])
        );

        // Log word: failing bits or raw beat pair
        assign cap_data[n*LOGW +: LOGW] = cfg_q.log_xor ? diff_flat[n*LOGW +: LOGW]
                                                        : {rd_late[n*LW +: LW], rd_early[n*LW +: LW]};
    end

    // Capture decision for the current beat pair
    always_comb begin
        any_mism = |mism_vec;
        pos_hit  = cfg_q.first_fail || (pos == cfg_q.pos_sel);
        seen     = beat_vld && any_mism;
        cap      = seen && pos_ok && pos_hit;
    end

    bl_log_bank #(.NLANE(LANES), .LOGW(LOGW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (log_clr),
        .cap      (cap),
        .seen     (seen),
        .cap_data (cap_data),
        .log_flat (log_flat),
        .done     (log_done),
        .any_fail (fail_seen)
    );

    // Early byte of the observed lane, zero when out of range
    always_comb begin
        obs_pick = '0;
        for (int i = 0; i < LANES; i++)
            if (cfg_q.obs_lane == SELW'(i))
                obs_pick = rd_early[i*LW +: LW];
    end

    // Latch the observed byte on each valid beat
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_byte <= '0;
        else if (beat_vld)
            last_byte <= obs_pick;
    end

    // Observation port: data byte or status bits
    assign obs_port = cfg_q.obs_data ? last_byte : {{(LW-2){1'b0}}, log_done, fail_seen};

    // R7
    bl4_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !bl8 && !cfg_q.first_fail && cfg_q.pos_sel[1] && !log_done && !log_clr)
        |=> !log_done);
    // R4
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && (cfg_q.cmp_lane > SELW'(LANES-1)) && (cfg_q.cmp_lane != ALL_LANES)
         && !fail_seen && !log_clr) |=> !fail_seen);
endmodule

// File: tb/test_burst_fail_logger.sv
`timescale 1ns/1ps
// Bench for burst_fail_logger: a vector table walked by one loop,
// then directed tests for reset and corner cases.
module test_burst_fail_logger;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [28:0]  cfg_wdata = '0;
    logic         log_clr = 1'b0;
    logic         beat_vld = 1'b0;
    logic         beat_first = 1'b0;
    logic         bl8 = 1'b0;
    logic [71:0]  rd_early = '0;
    logic [71:0]  rd_late = '0;
    logic [7:0]   exp_early = 8'h5A;
    logic [7:0]   exp_late = 8'hC3;
    logic [7:0]   obs_port;
    logic [143:0] log_flat;
    logic         log_done;
    logic         fail_seen;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    burst_fail_logger i_burst_fail_logger (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .log_clr(log_clr), .beat_vld(beat_vld), .beat_first(beat_first), .bl8(bl8),
        .rd_early(rd_early), .rd_late(rd_late), .exp_early(exp_early), .exp_late(exp_late),
        .obs_port(obs_port), .log_flat(log_flat), .log_done(log_done), .fail_seen(fail_seen)
    );

    typedef struct packed {
        logic [3:0] cmp;
        logic [1:0] pos;
        logic       ff;
        logic       lx;
        logic       b8;
        logic [3:0] fmask;
        logic [3:0] flane;
        logic       e_done;
        logic [1:0] e_pos;
        logic       e_any;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0001, 4'd3, 1'b1, 2'd0, 1'b1}, // R2 R6 R9
        '{4'd3, 2'd1, 1'b0, 1'b1, 1'b0, 4'b0001, 4'd3, 1'b0, 2'd0, 1'b1}, // R6 R11
        '{4'hF, 2'd1, 1'b0, 1'b1, 1'b0, 4'b0011, 4'd8, 1'b1, 2'd1, 1'b1}, // R3 R6 R9
        '{4'd2, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0001, 4'd5, 1'b0, 2'd0, 1'b0}, // R4
        '{4'hF, 2'd2, 1'b0, 1'b1, 1'b0, 4'b0011, 4'd0, 1'b0, 2'd0, 1'b1}, // R7
        '{4'hF, 2'd3, 1'b0, 1'b1, 1'b0, 4'b0011, 4'd0, 1'b0, 2'd0, 1'b1}, // R7
        '{4'd4, 2'd2, 1'b0, 1'b1, 1'b1, 4'b0110, 4'd4, 1'b1, 2'd2, 1'b1}, // R5 R6
        '{4'd4, 2'd3, 1'b0, 1'b0, 1'b1, 4'b1000, 4'd4, 1'b1, 2'd3, 1'b1}, // R6 R10
        '{4'd7, 2'd0, 1'b1, 1'b1, 1'b1, 4'b1100, 4'd7, 1'b1, 2'd2, 1'b1}, // R8
        '{4'hF, 2'd0, 1'b1, 1'b1, 1'b1, 4'b0000, 4'd0, 1'b0, 2'd0, 1'b0}, // R8
        '{4'd9, 2'd0, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd0, 1'b0, 2'd0, 1'b0}, // R4
        '{4'hF, 2'd1, 1'b0, 1'b0, 1'b1, 4'b0010, 4'd0, 1'b1, 2'd1, 1'b1}  // R3 R10
    };

    // Expected logs from the requirements: all lanes carry exp data, one lane perturbed
    function automatic logic [143:0] model(input logic [3:0] cmp, input logic lx,
                                           input int inj, input logic [7:0] em, input logic [7:0] lm);
        logic [143:0] r;
        r = '0;
        for (int n = 0; n < 9; n++) begin
            logic [7:0] e;
            logic [7:0] l;
            logic       sel;
            e   = 8'h5A ^ ((n == inj) ? em : 8'h00);
            l   = 8'hC3 ^ ((n == inj) ? lm : 8'h00);
            sel = (cmp == 4'hF) || (int'(cmp) == n);
            if (!lx)
                r[n*16 +: 16] = {l, e};
            else if (sel)
                r[n*16 +: 16] = {l ^ 8'hC3, e ^ 8'h5A};
            else
                r[n*16 +: 16] = {l ^ 8'h34, e ^ 8'h12};
        end
        return r;
    endfunction

    function automatic logic [28:0] mk_cfg(input logic [3:0] cmp, input logic [3:0] obs,
                                           input logic [1:0] pos, input logic ff,
                                           input logic lx, input logic od);
        return {8'h12, 8'h34, od, lx, ff, pos, obs, cmp};
    endfunction

    task automatic check(input string req, input logic [143:0] act, input logic [143:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [28:0] w);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic drive_beat(input logic first, input int inj, input logic [7:0] em, input logic [7:0] lm);
        @(negedge clk);
        beat_vld   = 1'b1;
        beat_first = first;
        for (int n = 0; n < 9; n++) begin
            rd_early[n*8 +: 8] = 8'h5A ^ ((n == inj) ? em : 8'h00);
            rd_late[n*8 +: 8]  = 8'hC3 ^ ((n == inj) ? lm : 8'h00);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        beat_vld   = 1'b0;
        beat_first = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 logs", log_flat, '0);
        check("R1 flags", {142'd0, log_done, fail_seen}, '0);
        check("R1 obs", {136'd0, obs_port}, '0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 per row comments
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int npos;
            int inj;
            logic [143:0] exp_log;
            v = VECS[i];
            pulse_clr();
            load_cfg(mk_cfg(v.cmp, 4'd0, v.pos, v.ff, v.lx, 1'b0));
            bl8  = v.b8;
            npos = v.b8 ? 4 : 2;
            for (int p = 0; p < npos; p++)
                drive_beat(p == 0, v.fmask[p] ? int'(v.flane) : -1, 8'h01 << p, 8'h80 >> p);
            idle();
            inj     = v.fmask[v.e_pos] ? int'(v.flane) : -1;
            exp_log = v.e_done ? model(v.cmp, v.lx, inj, 8'h01 << v.e_pos, 8'h80 >> v.e_pos) : '0;
            check($sformatf("R6 table row %0d done", i), {143'd0, log_done}, {143'd0, v.e_done});
            check($sformatf("R11 table row %0d fail_seen", i), {143'd0, fail_seen}, {143'd0, v.e_any});
            check($sformatf("R9 table row %0d logs", i), log_flat, exp_log);
        end

        // R3: late-only difference on a single compared lane
        pulse_clr();
        load_cfg(mk_cfg(4'd2, 4'd0, 2'd0, 1'b1, 1'b1, 1'b0));
        bl8 = 1'b0;
        drive_beat(1'b1, 2, 8'h00, 8'h01);
        idle();
        check("R3 late-only log", log_flat, model(4'd2, 1'b1, 2, 8'h00, 8'h01));

        // R5: failure only past the end of a four-beat burst
        pulse_clr();
        load_cfg(mk_cfg(4'hF, 4'd0, 2'd0, 1'b1, 1'b1, 1'b0));
        drive_beat(1'b1, -1, 8'h00, 8'h00);
        drive_beat(1'b0, -1, 8'h00, 8'h00);
        drive_beat(1'b0, 0, 8'h04, 8'h00);
        idle();
        check("R5 past end no capture", {142'd0, log_done, fail_seen}, {142'd0, 1'b0, 1'b1});
        check("R5 past end logs", log_flat, '0);

        // R11: sticky logs, second failure ignored
        pulse_clr();
        drive_beat(1'b1, 0, 8'h01, 8'h80);
        drive_beat(1'b0, -1, 8'h00, 8'h00);
        idle();
        check("R11 first capture", log_flat, 144'h8001);
        drive_beat(1'b1, 1, 8'hFF, 8'hFF);
        drive_beat(1'b0, 1, 8'hFF, 8'hFF);
        idle();
        check("R11 logs held", log_flat, 144'h8001);
        check("R11 done held", {143'd0, log_done}, 144'd1);

        // R12: clear empties, and beats alongside clear are dropped
        pulse_clr();
        check("R12 clear", {log_flat, 6'd0, log_done, fail_seen}, '0);
        @(negedge clk);
        log_clr    = 1'b1;
        beat_vld   = 1'b1;
        beat_first = 1'b1;
        rd_early   = {9{8'hA5}};
        @(negedge clk);
        log_clr = 1'b0;
        beat_vld = 1'b0;
        beat_first = 1'b0;
        check("R12 clear wins", {log_flat, 6'd0, log_done, fail_seen}, '0);

        // R13: observation of data and status
        load_cfg(mk_cfg(4'd9, 4'd6, 2'd0, 1'b0, 1'b1, 1'b1));
        drive_beat(1'b1, 6, 8'h2D, 8'h00);
        idle();
        check("R13 observed byte", {136'd0, obs_port}, 144'h77);
        load_cfg(mk_cfg(4'd9, 4'd10, 2'd0, 1'b0, 1'b1, 1'b1));
        drive_beat(1'b1, -1, 8'h00, 8'h00);
        idle();
        check("R13 lane out of range", {136'd0, obs_port}, '0);
        load_cfg(mk_cfg(4'hF, 4'd0, 2'd0, 1'b1, 1'b1, 1'b0));
        check("R13 status idle", {136'd0, obs_port}, '0);
        drive_beat(1'b1, 3, 8'h10, 8'h00);
        idle();
        check("R13 status set", {136'd0, obs_port}, 144'h03);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule